// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter Pair

This block holds two independent timer/counters, each made of a low byte and a high byte. Each unit either counts a one-cycle clock-enable tick (timer use) or falling edges seen on its external count pin (event counter use). A unit can be set so that it counts only while its external interrupt pin is high. This is useful for measuring how long a pulse lasts.

Software controls the pair through a small register file. A shared configuration byte selects, for each unit, its gating, its count source and one of four operating modes. A control byte holds the two run bits and the two overflow flags. The overflow flags also appear on an output port as interrupt requests. The interrupt controller clears a flag with a one-cycle acknowledge pulse when it takes the matching interrupt.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0x00 and `tf` is 00.
- R2: Register addresses are as follows. Address 0 is the configuration byte. Address 1 is the control byte. Addresses 2 and 3 are unit 0's low and high bytes. Addresses 4 and 5 are unit 1's low and high bytes. Addresses 6 and 7 read 0x00. A write takes effect at the clock edge on which `wr_en` is high. A counter byte write takes priority over counting on that same edge.
- R3: The configuration byte holds unit 1's fields in bits 7:4 and unit 0's fields in bits 3:0. Each nibble is ordered gate, event-select, mode[1], mode[0] from its high bit down. A unit counts only while its run bit is 1 and, if its gate bit is 1, its `gate_pin` bit is also high.
- R4: With event-select 0, an enabled unit advances once on each edge at which `tick` is 1.
- R5: With event-select 1, an enabled unit advances once for each falling edge of its `cnt_pin` bit. The step lands on the third rising clock edge after the pin goes low.
- R6: Mode 00 forms a 13-bit counter. Bits 4:0 of the low byte are the low part and the high byte is the upper part. Low-byte bits 7:5 are left unchanged. The counter wraps from 0x1FFF to 0 and sets the unit's flag.
- R7: Mode 01 forms a 16-bit counter that wraps from 0xFFFF to 0 and sets the unit's flag.
- R8: In mode 10 the low byte counts. When it steps past 0xFF it is loaded from the high byte and the unit's flag is set. The high byte is left unchanged.
- R9: When unit 0 is in mode 11, its low byte is an 8-bit counter under unit 0's run, gate and event-select bits, and it sets flag 0 on wrap. Its high byte advances on `tick` whenever run bit 1 is set, and it sets flag 1 on wrap.
- R10: A unit 1 in mode 11 holds its value. While unit 0 is in mode 11, unit 1 still counts but its wraps do not set flag 1.
- R11: An `ack` bit clears its flag. An overflow on the same edge wins, and the flag stays set.
- R12: The control byte is laid out from bit 7 down as flag 1, run 1, flag 0, run 0, then four spare read/write bits. A write to it sets both flags from the written data, overriding any overflow or acknowledge on that edge. `tf` is {flag 1, flag 0}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock-enable for timer use |
| cnt_pin | input | 2 | External event inputs, one per unit (asynchronous) |
| gate_pin | input | 2 | External interrupt pins used for gating, one per unit |
| ack | input | 2 | Acknowledge pulses that clear the flags |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| tf | output | 2 | Overflow flags {unit 1, unit 0} |

## Verification
The assertions assume that `gate_pin`, `tick`, `ack` and the write port are synchronous to `clk`. Only `cnt_pin` may change at any time, so only that input passes through the synchronizer. The bench changes every input a few nanoseconds after a rising edge, well clear of the next edge. It drives the count pins with levels held for at least one full cycle, so no edge is lost and the sampled values are never ambiguous. Write and acknowledge pulses last exactly one cycle. Random stimulus mixes every mode, gate setting and register write with these rules kept.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   typedef enum logic [1:0] {
      MODE_13     = 2'b00,
      MODE_16     = 2'b01,
      MODE_RELOAD = 2'b10,
      MODE_SPLIT  = 2'b11
   } tmr_mode_e;

   typedef struct packed {
      logic      gate;
      logic      evt;
      tmr_mode_e mode;
   } tmr_cfg_t;

   localparam logic [2:0] ADR_CFG = 3'd0;
   localparam logic [2:0] ADR_CTL = 3'd1;
   localparam logic [2:0] ADR_LO0 = 3'd2;
   localparam logic [2:0] ADR_HI0 = 3'd3;
   localparam logic [2:0] ADR_LO1 = 3'd4;
   localparam logic [2:0] ADR_HI1 = 3'd5;
endpackage

// File: rtl/tmr_fall_detect.sv
`timescale 1ns/1ps
module tmr_fall_detect #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin,
   output logic [W-1:0] fall
);
   initial begin
      assert (STAGES >= 1) else $error("tmr_fall_detect: STAGES must be at least 1");
      assert (W >= 1) else $error("tmr_fall_detect: W must be at least 1");
   end

   // pipe[0..STAGES-1] synchronise, pipe[STAGES] keeps the previous sample
   logic [STAGES:0][W-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], pin};
   end

   assign fall = pipe[STAGES] & ~pipe[STAGES-1];

   // R5
   fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|fall) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter import tmr_pkg::*; #(
   parameter int BW    = 8,
   parameter int PW    = 5,
   parameter bit SPLIT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  tmr_mode_e     mode,
   input  logic          en_lo,
   input  logic          en_hi,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [BW-1:0] wdata,
   output logic [BW-1:0] lo,
   output logic [BW-1:0] hi,
   output logic          ovf_lo,
   output logic          ovf_hi
);
   localparam int NW = BW + PW;
   localparam int FW = 2 * BW;

   initial begin
      assert (PW > 0 && PW < BW) else $error("tmr_counter: PW must lie in 1..BW-1");
   end

   logic [NW-1:0] narrow, narrow_inc;
   logic [FW-1:0] full_inc;
   logic [BW-1:0] lo_n, hi_n, sp_lo, sp_hi;
   logic          sp_ovl, sp_ovh;

   assign narrow     = {hi, lo[PW-1:0]};
   assign narrow_inc = narrow + 1'b1;
   assign full_inc   = {hi, lo} + 1'b1;

   generate
      if (SPLIT) begin : g_split
         assign sp_lo  = en_lo ? lo + 1'b1 : lo;
         assign sp_ovl = en_lo && (&lo);
         assign sp_hi  = en_hi ? hi + 1'b1 : hi;
         assign sp_ovh = en_hi && (&hi);
      end else begin : g_hold
         assign sp_lo  = lo;
         assign sp_hi  = hi;
         assign sp_ovl = 1'b0;
         assign sp_ovh = en_hi & 1'b0;
      end
   endgenerate

   always_comb begin
      lo_n   = lo;
      hi_n   = hi;
      ovf_lo = 1'b0;
      ovf_hi = 1'b0;
      unique case (mode)
         MODE_13: if (en_lo) begin
            lo_n   = {lo[BW-1:PW], narrow_inc[PW-1:0]};
            hi_n   = narrow_inc[NW-1:PW];
            ovf_lo = &narrow;
         end
         MODE_16: if (en_lo) begin
            {hi_n, lo_n} = full_inc;
            ovf_lo       = &{hi, lo};
         end
         MODE_RELOAD: if (en_lo) begin
            if (&lo) begin
               lo_n   = hi;
               ovf_lo = 1'b1;
            end else begin
               lo_n = lo + 1'b1;
            end
         end
         MODE_SPLIT: begin
            lo_n   = sp_lo;
            hi_n   = sp_hi;
            ovf_lo = sp_ovl;
            ovf_hi = sp_ovh;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo <= '0;
         hi <= '0;
      end else begin
         lo <= wr_lo ? wdata : lo_n;
         hi <= wr_hi ? wdata : hi_n;
      end
   end

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_lo && !en_hi && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));

   // R8
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RELOAD && ovf_lo && !wr_lo) |=> (lo == $past(hi)));

   generate
      if (!SPLIT) begin : g_hold_chk
         // R10
         split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
      end
   endgenerate
endmodule

// File: rtl/tmr_flags.sv
`timescale 1ns/1ps
module tmr_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic         wr,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] flag
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (wr)     flag[i] <= wdata[i];
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
         end
      end
   endgenerate

   // R11
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ((flag & $past(clr & ~set)) == '0));

   // R11
   ovf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (($past(set) & ~flag) == '0));

   // R12
   sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (flag == $past(wdata)));
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair import tmr_pkg::*; #(
   parameter int PRESC_W     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] cnt_pin,
   input  logic [1:0] gate_pin,
   input  logic [1:0] ack,
   input  logic       wr_en,
   input  logic [2:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rd_data,
   output logic [1:0] tf
);
   localparam int BW    = 8;
   localparam int UNITS = 2;

   initial begin
      assert (PRESC_W > 0 && PRESC_W < BW) else $error("tmr_pair: PRESC_W out of range");
      assert (SYNC_STAGES >= 2) else $error("tmr_pair: need two or more sync stages");
   end

   logic [7:0]       cfg_q;
   logic [UNITS-1:0] run_q;
   logic [3:0]       spare_q;
   tmr_cfg_t         cfg [UNITS];
   logic [UNITS-1:0] fall, en, ovf_lo, ovf_hi, flag_set;
   logic [BW-1:0]    lo [UNITS];
   logic [BW-1:0]    hi [UNITS];
   logic             wr_cfg, wr_ctl;

   assign wr_cfg = wr_en && (addr == ADR_CFG);
   assign wr_ctl = wr_en && (addr == ADR_CTL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         run_q   <= '0;
         spare_q <= '0;
      end else begin
         if (wr_cfg) cfg_q <= wdata;
         if (wr_ctl) begin
            run_q   <= {wdata[6], wdata[4]};
            spare_q <= wdata[3:0];
         end
      end
   end

   tmr_fall_detect #(.W(UNITS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(fall)
   );

   generate
      for (genvar u = 0; u < UNITS; u++) begin : g_unit
         localparam logic [2:0] ALO = (u == 0) ? ADR_LO0 : ADR_LO1;
         localparam logic [2:0] AHI = (u == 0) ? ADR_HI0 : ADR_HI1;
         logic src;

         assign cfg[u] = tmr_cfg_t'(cfg_q[4*u +: 4]);
         assign src    = cfg[u].evt ? fall[u] : tick;
         assign en[u]  = run_q[u] && (!cfg[u].gate || gate_pin[u]) && src;

         tmr_counter #(.BW(BW), .PW(PRESC_W), .SPLIT(u == 0)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (cfg[u].mode),
            .en_lo (en[u]),
            .en_hi ((u == 0) ? (run_q[1] && tick) : 1'b0),
            .wr_lo (wr_en && (addr == ALO)),
            .wr_hi (wr_en && (addr == AHI)),
            .wdata (wdata),
            .lo    (lo[u]),
            .hi    (hi[u]),
            .ovf_lo(ovf_lo[u]),
            .ovf_hi(ovf_hi[u])
         );
      end
   endgenerate

   assign flag_set[0] = ovf_lo[0];
   assign flag_set[1] = (cfg[0].mode == MODE_SPLIT) ? ovf_hi[0] : ovf_lo[1];

   tmr_flags #(.N(UNITS)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(ack),
      .wr(wr_ctl), .wdata({wdata[7], wdata[5]}), .flag(tf)
   );

   always_comb begin
      unique case (addr)
         ADR_CFG: rd_data = cfg_q;
         ADR_CTL: rd_data = {tf[1], run_q[1], tf[0], run_q[0], spare_q};
         ADR_LO0: rd_data = lo[0];
         ADR_HI0: rd_data = hi[0];
         ADR_LO1: rd_data = lo[1];
         ADR_HI1: rd_data = hi[1];
         default: rd_data = '0;
      endcase
   end

   // R9
   split_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[0].mode == MODE_SPLIT && !wr_ctl && !ovf_hi[0] && !tf[1]) |=> !tf[1]);
endmodule

// File: tb/tb_tmr_pair.sv
`timescale 1ns/1ps
module tb_tmr_pair;
   localparam int PERIOD = 10;

   logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
   logic [1:0] cnt_pin = '0, gate_pin = '0, ack = '0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rd_data;
   logic [1:0] tf;
   int total = 0, bad = 0;
   bit done = 0;

   tmr_pair dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
      .ack(ack), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data), .tf(tf)
   );

   always #(PERIOD/2) clk = ~clk;

   // behavioural reference model
   int m_lo[2], m_hi[2];
   bit [7:0] m_cfg;
   bit [3:0] m_spare;
   bit m_run[2], m_tf[2];
   bit [1:0] m_s1, m_s2, m_s3;

   always @(posedge clk) begin : mdl
      int v, md[2];
      bit [1:0] fl, en, ovl, setf;
      bit enh, ovh, gt, ev;
      if (!rst_n) begin
         m_lo = '{0, 0}; m_hi = '{0, 0}; m_cfg = 0; m_spare = 0;
         m_run = '{0, 0}; m_tf = '{0, 0}; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         fl = m_s3 & ~m_s2;
         for (int i = 0; i < 2; i++) begin
            gt = m_cfg[4*i+3];
            ev = m_cfg[4*i+2];
            md[i] = (m_cfg >> (4*i)) & 3;
            en[i] = m_run[i] && (!gt || gate_pin[i]) && (ev ? fl[i] : tick);
         end
         enh = m_run[1] && tick;
         ovl = 0; ovh = 0;
         for (int i = 0; i < 2; i++) begin
            case (md[i])
               0: if (en[i]) begin
                  v = m_hi[i] * 32 + m_lo[i] % 32;
                  if (v == 8191) ovl[i] = 1;
                  v = (v + 1) % 8192;
                  m_lo[i] = (m_lo[i] & 224) | (v % 32);
                  m_hi[i] = v / 32;
               end
               1: if (en[i]) begin
                  v = m_hi[i] * 256 + m_lo[i];
                  if (v == 65535) ovl[i] = 1;
                  v = (v + 1) % 65536;
                  m_lo[i] = v % 256;
                  m_hi[i] = v / 256;
               end
               2: if (en[i]) begin
                  if (m_lo[i] == 255) begin m_lo[i] = m_hi[i]; ovl[i] = 1; end
                  else m_lo[i] = m_lo[i] + 1;
               end
               default: if (i == 0) begin
                  if (en[0]) begin
                     if (m_lo[0] == 255) ovl[0] = 1;
                     m_lo[0] = (m_lo[0] + 1) % 256;
                  end
                  if (enh) begin
                     if (m_hi[0] == 255) ovh = 1;
                     m_hi[0] = (m_hi[0] + 1) % 256;
                  end
               end
            endcase
         end
         setf[0] = ovl[0];
         setf[1] = (md[0] == 3) ? ovh : ovl[1];
         for (int i = 0; i < 2; i++) begin
            if (wr_en && addr == 1) m_tf[i] = (i == 0) ? wdata[5] : wdata[7];
            else if (setf[i]) m_tf[i] = 1;
            else if (ack[i]) m_tf[i] = 0;
         end
         if (wr_en) begin
            case (addr)
               0: m_cfg = wdata;
               1: begin m_run[0] = wdata[4]; m_run[1] = wdata[6]; m_spare = wdata[3:0]; end
               2: m_lo[0] = wdata;
               3: m_hi[0] = wdata;
               4: m_lo[1] = wdata;
               5: m_hi[1] = wdata;
               default: ;
            endcase
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = cnt_pin;
      end
   end

   function automatic int mget(int a);
      case (a)
         0: return m_cfg;
         1: return {m_tf[1], m_run[1], m_tf[0], m_run[0], m_spare};
         2: return m_lo[0];
         3: return m_hi[0];
         4: return m_lo[1];
         5: return m_hi[1];
         default: return 0;
      endcase
   endfunction

   task automatic chk(string tag, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
      wr_en = 0;
      ack = 0;
      for (int a = 0; a < 6; a++) begin
         addr = a[2:0];
         #0.5;
         chk($sformatf("R2 model reg %0d", a), rd_data, mget(a));
      end
      chk("R11 model tf", tf, {m_tf[1], m_tf[0]});
   endtask

   task automatic run(int n);
      repeat (n) cyc();
   endtask

   task automatic wr(int a, int d);
      addr = a[2:0];
      wdata = d[7:0];
      wr_en = 1;
      cyc();
   endtask

   task automatic rd(int a, int exp, string tag);
      addr = a[2:0];
      #0.5;
      chk(tag, rd_data, exp);
   endtask

   task automatic pulse_tick();
      tick = 1; cyc(); tick = 0;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      run(3);
      rst_n = 1;
      // R1 reset state
      for (int a = 0; a < 6; a++) rd(a, 0, "R1 reset reg");
      chk("R1 reset tf", tf, 0);

      // R2 register map and readback
      wr(2, 8'h12); wr(3, 8'h34); wr(4, 8'h56); wr(5, 8'h78); wr(1, 8'h0F);
      rd(2, 8'h12, "R2 lo0"); rd(3, 8'h34, "R2 hi0"); rd(4, 8'h56, "R2 lo1");
      rd(5, 8'h78, "R2 hi1"); rd(1, 8'h0F, "R2 ctl");
      rd(7, 0, "R2 unused addr");
      wr(1, 8'h00);

      // R4 / R7 timer, 16-bit wrap
      wr(0, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h10);
      tick = 1; run(2); tick = 0;
      rd(2, 0, "R7 lo0 wrap"); rd(3, 0, "R7 hi0 wrap");
      chk("R7 tf set", tf, 2'b01);
      rd(1, 8'h30, "R12 ctl layout");
      ack = 2'b01; cyc();
      chk("R11 ack clears", tf, 2'b00);

      // R3 run/gate
      run(3);
      rd(2, 0, "R4 no tick no count");
      wr(0, 8'h09);
      tick = 1; run(3); tick = 0;
      rd(2, 0, "R3 gate low blocks");
      gate_pin = 2'b01;
      tick = 1; run(2); tick = 0;
      rd(2, 2, "R3 gate high counts");
      tick = 1; wr(2, 8'h40); tick = 0;
      rd(2, 8'h40, "R2 write beats count");
      gate_pin = 0;

      // R5 event counting
      wr(0, 8'h05); wr(2, 0); wr(3, 0);
      tick = 1;
      for (int k = 0; k < 3; k++) begin
         cnt_pin = 2'b01; run(3);
         cnt_pin = 2'b00; run(3);
      end
      run(3); tick = 0;
      rd(2, 3, "R5 three falls");

      // R6 13-bit
      wr(0, 8'h00); wr(2, 8'h1F); wr(3, 8'h05);
      pulse_tick();
      rd(2, 8'h00, "R6 prescale carry lo"); rd(3, 8'h06, "R6 prescale carry hi");
      wr(2, 8'hFF); wr(3, 8'hFF);
      pulse_tick();
      rd(2, 8'hE0, "R6 wrap keeps top bits"); rd(3, 0, "R6 wrap hi");
      chk("R6 flag", tf, 2'b01);
      wr(1, 8'h10);

      // R8 auto-reload
      wr(0, 8'h02); wr(3, 8'hC0); wr(2, 8'hFF);
      pulse_tick();
      rd(2, 8'hC0, "R8 reload"); rd(3, 8'hC0, "R8 hi kept");
      chk("R8 flag", tf, 2'b01);
      pulse_tick();
      rd(2, 8'hC1, "R8 after reload");
      wr(1, 8'h10);

      // R9 split mode
      wr(0, 8'h03); wr(2, 8'hFF); wr(3, 8'hFF); wr(1, 8'h50);
      pulse_tick();
      rd(2, 0, "R9 lo0 wrap"); rd(3, 0, "R9 hi0 wrap");
      chk("R9 both flags", tf, 2'b11);

      // R10 unit 1 with unit 0 split
      wr(0, 8'h13); wr(4, 8'hFF); wr(5, 8'hFF); wr(3, 0); wr(1, 8'h50);
      pulse_tick();
      rd(4, 0, "R10 lo1 wraps"); rd(5, 0, "R10 hi1 wraps"); rd(3, 1, "R9 hi0 on run1");
      chk("R10 no flag1", tf, 2'b00);
      wr(0, 8'h30); wr(4, 8'h10);
      tick = 1; run(3); tick = 0;
      rd(4, 8'h10, "R10 unit1 mode3 holds");

      // R11 overflow beats ack
      wr(0, 8'h01); wr(2, 8'hFF); wr(3, 8'hFF); wr(1, 8'h10);
      tick = 1; ack = 2'b01; cyc(); tick = 0;
      chk("R11 ovf beats ack", tf, 2'b01);

      // R12 software write priority
      ack = 2'b11; wr(1, 8'hB0);
      chk("R12 write sets over ack", tf, 2'b11);
      wr(2, 8'hFF); wr(3, 8'hFF);
      tick = 1; wr(1, 8'h10); tick = 0;
      chk("R12 write clears over ovf", tf, 2'b00);

      // random mix against the model
      for (int n = 0; n < 4000; n++) begin
         tick = 1'($urandom);
         gate_pin = 2'($urandom);
         if ($urandom % 3 == 0) cnt_pin = 2'($urandom);
         ack = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
         if ($urandom % 12 == 0) begin
            addr = 3'($urandom % 6);
            wdata = 8'($urandom);
            wr_en = 1;
         end
         cyc();
      end

      done = 1;
      summary();
      $finish;
   end
endmodule